// File: doc/BRIEF.md
# Ranked Median and Centre-Average Sample Filter

This block turns a short burst of raw converter samples into one filtered reading. Each sample that is accepted goes into its place in an ascending list at once. The block then stalls for a fixed settling time before it takes the next sample. When the burst holds the configured number of samples, the block forms the output. With the averaging option off, the output is the median of the list. With it on, the output is a 1-2-1 weighted mean of the median and its two neighbours, which needs only shifts and adds.

The result goes into a per-channel result register first. In the next cycle it is compared against that channel's unsigned low and high limits. A limit violation sets a sticky low or high alert bit for the channel. An interrupt line is the OR of all alert bits whose channel is not masked. The block's user supplies the samples, the limits, the masks and the clear strobes; converter control and the register bus sit outside the block.

Top module: `median_avg_filter`

## Requirements
- R1: A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both high. After each taken sample, `smp_ready` stays low for exactly SORT_CYC cycles (default 3). Samples offered while `smp_ready` is low are ignored and never enter the burst.
- R2: `cfg_size` selects the burst length: code 0 = 1 sample, 1 = 3, 2 = 5, 3 = 7. One result is produced after that many samples.
- R3: With averaging off, the result is the median of the burst: ranked element k of the ascending list, where k is the size code.
- R4: With averaging on, the result is (r[k-1] + 2*r[k] + r[k+1]) >> 2, truncated, where r is the ascending list. With size code 0 the single sample passes through unchanged.
- R5: The result is written into channel c's register, seen on `res_all[c*12 +: 12]`, one cycle before `res_valid` is high. `res_valid` lasts one cycle and `res_chan` names the channel. The registers of other channels do not change.
- R6: In the cycle after `res_valid`, `alert_lo[c]` is set if the result is strictly below `lim_lo[c*12 +: 12]`. `alert_hi[c]` is set if the result is strictly above `lim_hi[c*12 +: 12]`. A result equal to a limit sets no flag.
- R7: Alert bits stay set until a 1 on `clr_lo[c]` or `clr_hi[c]` clears that bit on the next edge.
- R8: `irq` is high exactly when some alert bit of a channel whose `irq_mask` bit is 0 is set. Masking does not change the alert bits.
- R9: After reset, `smp_ready` is 1, `res_valid` is 0, every result register is 0, every alert bit is 0 and `irq` is 0.
- R10: The channel, size code and averaging option are captured with the first sample of a burst. Changes to `smp_chan`, `cfg_size` or `cfg_avg` during the rest of the burst have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 2 | Burst length code (1, 3, 5 or 7 samples) |
| cfg_avg | input | 1 | Enables the centre average |
| smp_valid | input | 1 | Sample offered |
| smp_chan | input | CHW | Channel of the burst (taken with the first sample) |
| smp_data | input | DW | Raw sample value |
| smp_ready | output | 1 | Block can take a sample |
| lim_lo | input | NCH*DW | Per-channel low limits |
| lim_hi | input | NCH*DW | Per-channel high limits |
| irq_mask | input | NCH | 1 masks the channel's alerts from irq |
| clr_lo | input | NCH | Write-one clear of the low alert bits |
| clr_hi | input | NCH | Write-one clear of the high alert bits |
| res_valid | output | 1 | One-cycle marker of a fresh result |
| res_chan | output | CHW | Channel of the fresh result |
| res_all | output | NCH*DW | All per-channel result registers |
| alert_lo | output | NCH | Sticky below-limit flags |
| alert_hi | output | NCH | Sticky above-limit flags |
| irq | output | 1 | Interrupt |

## Verification
The bench offers junk samples while the block is ranking. A block that took them would shift the median toward 4095. It also changes the channel, size and averaging inputs in the middle of a burst. A block that followed the new size would finish early, and one that followed the new channel would corrupt the other channel's register. Results that equal a limit exactly must raise no flag, so an off-by-one comparator shows up as a spurious alert. Flags are then masked and cleared one channel at a time. This catches an interrupt that ignores the mask, flags that forget their state, and clears that reach the wrong bit.

// File: rtl/mavf_pkg.sv
package mavf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SORT  = 2'd1,
    ST_WRITE = 2'd2,
    ST_CHECK = 2'd3
  } mavf_state_e;

  // number of samples in a burst for a given size code (2*code+1)
  function automatic logic [2:0] burst_len(input logic [1:0] code);
    return {code, 1'b1};
  endfunction

  // 1-2-1 weighted mean of three neighbours, shifts and adds only
  function automatic logic [31:0] smooth3(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input logic [31:0] c);
    return (a + (b << 1) + c) >> 2;
  endfunction

  function automatic logic under_lim(input logic [31:0] v, input logic [31:0] lim);
    return v < lim;
  endfunction

  function automatic logic over_lim(input logic [31:0] v, input logic [31:0] lim);
    return v > lim;
  endfunction

endpackage

// File: rtl/mavf_rank_list.sv
module mavf_rank_list #(
  parameter int DW    = 12,
  parameter int DEPTH = 7,
  parameter int CW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins,
  input  logic [CW-1:0]       fill,
  input  logic [DW-1:0]       din,
  output logic [DEPTH*DW-1:0] ranks
);

  logic [DEPTH-1:0][DW-1:0] slot_q;
  logic [DEPTH-1:0][DW-1:0] slot_d;
  logic [DEPTH-1:0]         keep;
  logic [DEPTH-1:0]         wr_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    // an occupied slot whose value is not above the new sample stays put
    assign keep[i] = (i < int'(fill)) && (slot_q[i] <= din);
    if (i == 0) begin : g_head
      assign slot_d[i] = keep[i] ? slot_q[i] : din;
      assign wr_en[i]  = ins;
    end else begin : g_body
      assign slot_d[i] = keep[i]   ? slot_q[i]   :
                         keep[i-1] ? din         : slot_q[i-1];
      assign wr_en[i]  = ins && (i <= int'(fill));
    end
    assign ranks[i*DW +: DW] = slot_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        if (wr_en[j]) slot_q[j] <= slot_d[j];
      end
    end
  end

endmodule

// File: rtl/mavf_pick.sv
module mavf_pick #(
  parameter int DW    = 12,
  parameter int DEPTH = 7
) (
  input  logic [DEPTH*DW-1:0] ranks,
  input  logic [1:0]          code,
  input  logic                avg_en,
  output logic [DW-1:0]       median,
  output logic [DW-1:0]       centre_avg,
  output logic [DW-1:0]       pick
);

  import mavf_pkg::*;

  logic [DW-1:0] slot [DEPTH];
  logic [2:0]    idx_mid;
  logic [2:0]    idx_lo;
  logic [2:0]    idx_hi;
  logic [DW-1:0] nb_lo;
  logic [DW-1:0] nb_hi;

  for (genvar i = 0; i < DEPTH; i++) begin : g_unpack
    assign slot[i] = ranks[i*DW +: DW];
  end

  assign idx_mid = {1'b0, code};
  assign idx_lo  = (code == 2'd0) ? 3'd0 : idx_mid - 3'd1;
  assign idx_hi  = (code == 2'd0) ? 3'd0 : idx_mid + 3'd1;

  assign median = slot[idx_mid];
  assign nb_lo  = slot[idx_lo];
  assign nb_hi  = slot[idx_hi];

  assign centre_avg = (code == 2'd0) ? median :
                      DW'(smooth3(32'(nb_lo), 32'(median), 32'(nb_hi)));

  assign pick = avg_en ? centre_avg : median;

endmodule

// File: rtl/mavf_alert_bank.sv
module mavf_alert_bank #(
  parameter int NCH = 2,
  parameter int DW  = 12,
  parameter int CHW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk,
  input  logic [CHW-1:0]    chk_ch,
  input  logic [DW-1:0]     val,
  input  logic [NCH*DW-1:0] lim_lo,
  input  logic [NCH*DW-1:0] lim_hi,
  input  logic [NCH-1:0]    irq_mask,
  input  logic [NCH-1:0]    clr_lo,
  input  logic [NCH-1:0]    clr_hi,
  output logic [NCH-1:0]    alert_lo,
  output logic [NCH-1:0]    alert_hi,
  output logic              irq
);

  import mavf_pkg::*;

  logic [NCH-1:0] hit_lo;
  logic [NCH-1:0] hit_hi;
  logic [NCH-1:0] live;

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    logic sel;
    assign sel       = chk && (int'(chk_ch) == c);
    assign hit_lo[c] = sel && under_lim(32'(val), 32'(lim_lo[c*DW +: DW]));
    assign hit_hi[c] = sel && over_lim(32'(val), 32'(lim_hi[c*DW +: DW]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_lo <= '0;
      alert_hi <= '0;
    end else begin
      alert_lo <= (alert_lo & ~clr_lo) | hit_lo;
      alert_hi <= (alert_hi & ~clr_hi) | hit_hi;
    end
  end

  assign live = (alert_lo | alert_hi) & ~irq_mask;
  assign irq  = |live;

endmodule

// File: rtl/median_avg_filter.sv
module median_avg_filter #(
  parameter int NCH      = 2,
  parameter int DW       = 12,
  parameter int SORT_CYC = 3,
  parameter int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_avg,
  input  logic              smp_valid,
  input  logic [CHW-1:0]    smp_chan,
  input  logic [DW-1:0]     smp_data,
  output logic              smp_ready,
  input  logic [NCH*DW-1:0] lim_lo,
  input  logic [NCH*DW-1:0] lim_hi,
  input  logic [NCH-1:0]    irq_mask,
  input  logic [NCH-1:0]    clr_lo,
  input  logic [NCH-1:0]    clr_hi,
  output logic              res_valid,
  output logic [CHW-1:0]    res_chan,
  output logic [NCH*DW-1:0] res_all,
  output logic [NCH-1:0]    alert_lo,
  output logic [NCH-1:0]    alert_hi,
  output logic              irq
);

  import mavf_pkg::*;

  localparam int DEPTH = 7;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TW    = (SORT_CYC > 1) ? $clog2(SORT_CYC) : 1;

  mavf_state_e           state;
  logic [CW-1:0]         rank_cnt;
  logic [TW-1:0]         tmr;
  logic [CHW-1:0]        burst_ch;
  logic [1:0]            burst_code;
  logic                  burst_avg;
  logic [NCH-1:0][DW-1:0] res_q;

  // named internal events
  logic                  take_evt;
  logic                  first_evt;
  logic                  sort_end;
  logic                  burst_full;
  logic [DEPTH*DW-1:0]   rank_flat;
  logic [DW-1:0]         med_val;
  logic [DW-1:0]         avg_val;
  logic [DW-1:0]         filt_val;

  assign smp_ready  = (state == ST_IDLE);
  assign take_evt   = smp_valid && smp_ready;
  assign first_evt  = take_evt && (rank_cnt == '0);
  assign sort_end   = (state == ST_SORT) && (tmr == '0);
  assign burst_full = (rank_cnt == CW'(burst_len(burst_code)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rank_cnt   <= '0;
      tmr        <= '0;
      burst_ch   <= '0;
      burst_code <= '0;
      burst_avg  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_evt) begin
            if (first_evt) begin
              burst_ch   <= smp_chan;
              burst_code <= cfg_size;
              burst_avg  <= cfg_avg;
            end
            rank_cnt <= rank_cnt + 1'b1;
            tmr      <= TW'(SORT_CYC - 1);
            state    <= ST_SORT;
          end
        end
        ST_SORT: begin
          if (sort_end) state <= burst_full ? ST_WRITE : ST_IDLE;
          else          tmr   <= tmr - 1'b1;
        end
        ST_WRITE: state <= ST_CHECK;
        ST_CHECK: begin
          rank_cnt <= '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (state == ST_WRITE) begin
      res_q[burst_ch] <= filt_val;
    end
  end

  mavf_rank_list #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rank (
    .clk   (clk),
    .rst_n (rst_n),
    .ins   (take_evt),
    .fill  (rank_cnt),
    .din   (smp_data),
    .ranks (rank_flat)
  );

  mavf_pick #(.DW(DW), .DEPTH(DEPTH)) u_pick (
    .ranks      (rank_flat),
    .code       (burst_code),
    .avg_en     (burst_avg),
    .median     (med_val),
    .centre_avg (avg_val),
    .pick       (filt_val)
  );

  mavf_alert_bank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_alert (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk      (state == ST_CHECK),
    .chk_ch   (burst_ch),
    .val      (res_q[burst_ch]),
    .lim_lo   (lim_lo),
    .lim_hi   (lim_hi),
    .irq_mask (irq_mask),
    .clr_lo   (clr_lo),
    .clr_hi   (clr_hi),
    .alert_lo (alert_lo),
    .alert_hi (alert_hi),
    .irq      (irq)
  );

  assign res_valid = (state == ST_CHECK);
  assign res_chan  = burst_ch;
  assign res_all   = res_q;

endmodule

// File: rtl/median_avg_filter_sva.sv
module median_avg_filter_sva #(
  parameter int NCH   = 2,
  parameter int DW    = 12,
  parameter int DEPTH = 7,
  parameter int CW    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              res_valid,
  input logic [NCH*DW-1:0] res_all,
  input logic [NCH-1:0]    alert_lo,
  input logic [NCH-1:0]    alert_hi,
  input logic [NCH-1:0]    clr_lo,
  input logic [NCH-1:0]    clr_hi,
  input logic [NCH-1:0]    irq_mask,
  input logic              irq,
  input logic [DEPTH*DW-1:0] rank_flat,
  input logic [CW-1:0]     rank_cnt
);

  logic sorted_ok;

  always_comb begin
    sorted_ok = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if ((i + 1) < int'(rank_cnt) &&
          rank_flat[i*DW +: DW] > rank_flat[(i+1)*DW +: DW]) sorted_ok = 1'b0;
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  assert_rank_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sorted_ok);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_res_before_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_all) |-> res_valid);

  assert_irq_no_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_lo == '0 && alert_hi == '0) |-> !irq);

  assert_irq_all_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_lo_after_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alert_lo[c]) |-> $past(res_valid));
    assert_hi_after_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alert_hi[c]) |-> $past(res_valid));
    assert_lo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alert_lo[c]) |-> $past(clr_lo[c]));
    assert_hi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alert_hi[c]) |-> $past(clr_hi[c]));
  end

endmodule

bind median_avg_filter median_avg_filter_sva #(
  .NCH(NCH), .DW(DW), .DEPTH(DEPTH), .CW(CW)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .res_valid (res_valid),
  .res_all   (res_all),
  .alert_lo  (alert_lo),
  .alert_hi  (alert_hi),
  .clr_lo    (clr_lo),
  .clr_hi    (clr_hi),
  .irq_mask  (irq_mask),
  .irq       (irq),
  .rank_flat (rank_flat),
  .rank_cnt  (rank_cnt)
);

// File: tb/test_median_avg_filter.sv
module test_median_avg_filter;

  localparam int NCH = 2;
  localparam int DW = 12;
  localparam int SORT_CYC = 3;
  localparam int CHW = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [1:0]        cfg_size;
  logic              cfg_avg;
  logic              smp_valid;
  logic [CHW-1:0]    smp_chan;
  logic [DW-1:0]     smp_data;
  logic              smp_ready;
  logic [NCH*DW-1:0] lim_lo;
  logic [NCH*DW-1:0] lim_hi;
  logic [NCH-1:0]    irq_mask;
  logic [NCH-1:0]    clr_lo;
  logic [NCH-1:0]    clr_hi;
  logic              res_valid;
  logic [CHW-1:0]    res_chan;
  logic [NCH*DW-1:0] res_all;
  logic [NCH-1:0]    alert_lo;
  logic [NCH-1:0]    alert_hi;
  logic              irq;

  median_avg_filter #(.NCH(NCH), .DW(DW), .SORT_CYC(SORT_CYC), .CHW(CHW)) i_median_avg_filter (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_avg(cfg_avg),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data), .smp_ready(smp_ready),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .irq_mask(irq_mask), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .res_valid(res_valid), .res_chan(res_chan), .res_all(res_all),
    .alert_lo(alert_lo), .alert_hi(alert_hi), .irq(irq)
  );

  typedef struct { int ch; int val; string tag; } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int res_model[NCH];
  bit lo_m[NCH];
  bit hi_m[NCH];

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_irq();
    int r = 0;
    for (int c = 0; c < NCH; c++) if ((lo_m[c] || hi_m[c]) && !irq_mask[c]) r = 1;
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected result act=%0d exp=none", res_all[res_chan*DW +: DW]);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R5", int'(res_chan), e.ch, "result channel");
        chk(e.tag, int'(res_all[e.ch*DW +: DW]), e.val, "result value");
        res_model[e.ch] = e.val;
        for (int c = 0; c < NCH; c++)
          chk("R5", int'(res_all[c*DW +: DW]), res_model[c], "result register bank");
        if (e.val < int'(lim_lo[e.ch*DW +: DW])) lo_m[e.ch] = 1'b1;
        if (e.val > int'(lim_hi[e.ch*DW +: DW])) hi_m[e.ch] = 1'b1;
        done_cnt++;
      end
    end
  end

  task automatic check_flags(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk(tag, int'(alert_lo[c]), int'(lo_m[c]), "low alert");
      chk(tag, int'(alert_hi[c]), int'(hi_m[c]), "high alert");
    end
    chk("R8", int'(irq), exp_irq(), "irq");
  endtask

  // driver: computes the expected value, queues it, sends the burst
  task automatic run_burst(input int ch, input int code, input bit avg, input int d[7],
                           input bit noisy, input bit twist, input string tag);
    int n = 2 * code + 1;
    int s[7];
    int ev;
    int target;
    exp_t e;
    for (int j = 0; j < 7; j++) s[j] = d[j];
    for (int a = 0; a < n; a++)
      for (int b = 0; b < n - 1 - a; b++)
        if (s[b] > s[b+1]) begin int t = s[b]; s[b] = s[b+1]; s[b+1] = t; end
    if (avg && code > 0) ev = (s[code-1] + 2 * s[code] + s[code+1]) / 4;
    else ev = s[code];
    e.ch = ch; e.val = ev; e.tag = tag;
    sb.push_back(e);
    target = done_cnt + 1;
    cfg_size = 2'(code);
    cfg_avg = avg;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      smp_chan = (twist && j > 0) ? CHW'(1 - ch) : CHW'(ch);
      smp_data = DW'(d[j]);
      smp_valid = 1'b1;
      while (!smp_ready) @(negedge clk);
      @(posedge clk); #1;
      if (twist && j == 0) begin
        cfg_size = 2'(~code);
        cfg_avg = !avg;
      end
      if (noisy) begin
        int busy = 0;
        smp_data = '1;
        forever begin
          @(negedge clk);
          if (smp_ready) break;
          busy++;
        end
        smp_valid = 1'b0;
        if (j < n - 1) chk("R1", busy, SORT_CYC, "ready-low cycles after a take");
      end else begin
        smp_valid = 1'b0;
      end
    end
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
    check_flags("R6");
  endtask

  task automatic set_lims(input int ch, input int lo, input int hi);
    lim_lo[ch*DW +: DW] = DW'(lo);
    lim_hi[ch*DW +: DW] = DW'(hi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_size = '0; cfg_avg = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_data = '0;
    lim_lo = '0; lim_hi = '1; irq_mask = '0; clr_lo = '0; clr_hi = '0;
    for (int c = 0; c < NCH; c++) begin res_model[c] = 0; lo_m[c] = 0; hi_m[c] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9", int'(smp_ready), 1, "ready after reset");
    chk("R9", int'(res_valid), 0, "res_valid after reset");
    chk("R9", int'(res_all), 0, "results after reset");
    chk("R9", int'({alert_hi, alert_lo}), 0, "alerts after reset");
    chk("R9", int'(irq), 0, "irq after reset");

    run_burst(0, 0, 0, '{100, 0, 0, 0, 0, 0, 0}, 0, 0, "R2");
    run_burst(0, 1, 0, '{900, 5, 300, 0, 0, 0, 0}, 0, 0, "R3");
    run_burst(1, 2, 1, '{10, 400, 20, 30, 1000, 0, 0}, 0, 0, "R4");
    run_burst(0, 3, 0, '{70, 10, 60, 20, 50, 30, 40}, 1, 0, "R1");
    run_burst(1, 3, 1, '{7, 1, 6, 2, 5, 3, 4}, 0, 1, "R10");
    run_burst(0, 0, 1, '{2345, 0, 0, 0, 0, 0, 0}, 0, 0, "R4");

    // limits: below low, at each limit exactly, above high
    set_lims(0, 500, 3000);
    run_burst(0, 1, 0, '{450, 100, 499, 0, 0, 0, 0}, 0, 0, "R6");
    set_lims(1, 200, 800);
    run_burst(1, 1, 1, '{800, 800, 800, 0, 0, 0, 0}, 0, 0, "R6");
    run_burst(1, 1, 1, '{200, 200, 200, 0, 0, 0, 0}, 0, 0, "R6");
    run_burst(1, 1, 0, '{801, 900, 850, 0, 0, 0, 0}, 0, 0, "R6");
    run_burst(0, 1, 0, '{1000, 1200, 1100, 0, 0, 0, 0}, 0, 0, "R7");

    // masking
    @(negedge clk);
    irq_mask = 2'b01;
    #1 chk("R8", int'(irq), exp_irq(), "irq with channel 0 masked");
    irq_mask = 2'b11;
    #1 chk("R8", int'(irq), 0, "irq with all masked");
    check_flags("R8");
    irq_mask = 2'b10;
    #1 chk("R8", int'(irq), exp_irq(), "irq with channel 1 masked");
    irq_mask = 2'b00;

    // clearing
    @(negedge clk);
    clr_lo = 2'b01;
    @(negedge clk);
    clr_lo = 2'b00;
    lo_m[0] = 1'b0;
    check_flags("R7");
    clr_hi = 2'b10;
    @(negedge clk);
    clr_hi = 2'b00;
    hi_m[1] = 1'b0;
    check_flags("R7");
    chk("R7", int'(irq), 0, "irq after all clears");

    repeat (4) @(negedge clk);
    chk("R2", sb.size(), 0, "pending expected results");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule